// File: doc/BRIEF.md
# Cell Bleed Switch Arbiter

This block decides, every clock cycle, which of a set of cell-bleed discharge switches are closed. Several control sources compete for each switch, and a fixed five-level order settles them. From strongest to weakest, the levels are: an over-temperature shutdown, a global mute, a per-cell forced-on mask, a pause while a voltage measurement runs, and per-cell pulse-width bleeding. The forced-on mask outranks the measurement pause. Pulse-width bleeding yields to that pause.

Pulse-width bleeding uses a slow frame of sixteen equal slots. A prescaler sets the slot length in clock cycles. At the default setting the frame lasts about one second at a 4 MHz clock, and a bench can choose a much shorter frame. Each cell has a 4-bit duty code. The cell bleeds in the first `code` slots of every frame. A countdown timer limits how long pulse-width bleeding lasts: it is loaded with a number of frames, steps down once per frame, and reports expiry when it reaches zero. The switch outputs come straight from flip-flops.

Top module: `bleed_switch_ctrl`

## Requirements
- R1: While `therm_shdn` is 1, every bit of `sw_on` is 0 one cycle later, whatever the other inputs are.
- R2: While `mute` is 1, every bit of `sw_on` is 0 one cycle later, whatever the lower-priority inputs are.
- R3: While neither `therm_shdn` nor `mute` is 1, bit i of `direct_en` set to 1 drives `sw_on[i]` to 1 one cycle later. This holds regardless of `adc_busy`, the duty code or the timer.
- R4: While `adc_busy` is 1 (and neither shutdown nor mute is active), every switch whose `direct_en` bit is 0 is off one cycle later.
- R5: The duty code of cell i is `duty_codes[4i+3:4i]`. A frame is 16 slots of `SLOT_TICKS` cycles each. With no higher source active, cell i is on during slots whose index is below its code, which gives code × `SLOT_TICKS` on-cycles per frame. Code 0 keeps the cell off.
- R6: A cycle with `tmr_load` 1 sets the frame countdown to `tmr_value`. The countdown drops by one at the end of each frame while it is nonzero. `tmr_expired` is 1 exactly when the countdown is zero. Loading 0 gives `tmr_expired` 1 on the next cycle.
- R7: While `tmr_expired` is 1, pulse-width bleeding is stopped, so only switches held by `direct_en` can be on.
- R8: After reset, `sw_on` is all zero and `tmr_expired` is 1 (the countdown starts at zero). Every switch output changes only one cycle after the inputs that cause the change.
- R9: Loading a nonzero `tmr_value` makes `tmr_expired` 0 on the next cycle. `tmr_expired` stays 1 until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| therm_shdn | input | 1 | Over-temperature shutdown, top priority |
| mute | input | 1 | Opens all switches |
| direct_en | input | NUM_CELLS | Per-cell forced-on mask |
| adc_busy | input | 1 | Measurement in progress; pauses pulse-width bleeding |
| duty_codes | input | NUM_CELLS*DUTY_W | Packed per-cell duty codes, cell 0 in the low bits |
| tmr_load | input | 1 | Load strobe for the frame countdown |
| tmr_value | input | TMR_W | Countdown value in frames |
| sw_on | output | NUM_CELLS | Registered switch enables |
| tmr_expired | output | 1 | Countdown at zero |

## Verification
The collision of interest is a measurement pause landing in the same cycles as a forced-on mask while pulse-width bleeding is asking for every cell at full duty. The bench holds all three active together for a whole frame. It expects the masked cells to be on for the entire frame and every other cell to get zero on-cycles. A second collision is the countdown expiring while cells are mid-frame. The bench measures when expiry appears after a load, then counts on-cycles across a frame after expiry to confirm that pulse-width bleeding stopped and the forced-on cells kept running.

// File: rtl/bleed_pkg.sv
package bleed_pkg;

   // Which level of the priority stack settled a switch this cycle.
   typedef enum logic [2:0] {
      SRC_THERMAL = 3'd0,
      SRC_MUTE    = 3'd1,
      SRC_DIRECT  = 3'd2,
      SRC_ADC     = 3'd3,
      SRC_PWM     = 3'd4,
      SRC_IDLE    = 3'd5
   } bleed_src_e;

   function automatic logic src_closes(input bleed_src_e s);
      return (s == SRC_DIRECT) || (s == SRC_PWM);
   endfunction

endpackage

// File: rtl/bleed_timebase.sv
module bleed_timebase #(
   parameter int SLOT_TICKS = 15625,
   parameter int DUTY_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [DUTY_W-1:0] slot_idx,
   output logic              period_tick
);
   localparam int PRE_W = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
   localparam logic [DUTY_W-1:0] LAST_SLOT = '1;

   logic slot_tick;

   generate
      if (SLOT_TICKS < 1) begin : g_bad_ticks
         $error("bleed_timebase: SLOT_TICKS must be at least 1");
      end
      if (SLOT_TICKS == 1) begin : g_no_pre
         assign slot_tick = 1'b1;
      end else begin : g_pre
         localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(SLOT_TICKS - 1);
         logic [PRE_W-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (pre_q == PRE_LAST) begin
               pre_q <= '0;
            end else begin
               pre_q <= pre_q + 1'b1;
            end
         end
         assign slot_tick = (pre_q == PRE_LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_idx <= '0;
      end else if (slot_tick) begin
         slot_idx <= slot_idx + 1'b1;
      end
   end

   assign period_tick = slot_tick && (slot_idx == LAST_SLOT);

endmodule

// File: rtl/bleed_dis_timer.sv
module bleed_dis_timer #(
   parameter int TMR_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TMR_W-1:0] load_val,
   input  logic             period_tick,
   output logic             expired
);
   logic [TMR_W-1:0] count_q;

   generate
      if (TMR_W < 1) begin : g_bad_w
         $error("bleed_dis_timer: TMR_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (load) begin
         count_q <= load_val;
      end else if (period_tick && (count_q != '0)) begin
         count_q <= count_q - 1'b1;
      end
   end

   assign expired = (count_q == '0);

endmodule

// File: rtl/bleed_cell_resolve.sv
module bleed_cell_resolve
   import bleed_pkg::*;
#(
   parameter int DUTY_W = 4
) (
   input  logic              thermal,
   input  logic              mute,
   input  logic              direct,
   input  logic              adc_busy,
   input  logic              pwm_allow,
   input  logic [DUTY_W-1:0] slot_idx,
   input  logic [DUTY_W-1:0] duty,
   output logic              sw_next
);
   bleed_src_e src;
   logic       pwm_want;

   assign pwm_want = pwm_allow && (slot_idx < duty);

   always_comb begin
      if (thermal) begin
         src = SRC_THERMAL;
      end else if (mute) begin
         src = SRC_MUTE;
      end else if (direct) begin
         src = SRC_DIRECT;
      end else if (adc_busy) begin
         src = SRC_ADC;
      end else if (pwm_want) begin
         src = SRC_PWM;
      end else begin
         src = SRC_IDLE;
      end
   end

   assign sw_next = src_closes(src);

endmodule

// File: rtl/bleed_switch_ctrl.sv
module bleed_switch_ctrl #(
   parameter int NUM_CELLS  = 16,
   parameter int DUTY_W     = 4,
   parameter int SLOT_TICKS = 250000,
   parameter int TMR_W      = 12
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        therm_shdn,
   input  logic                        mute,
   input  logic [NUM_CELLS-1:0]        direct_en,
   input  logic                        adc_busy,
   input  logic [NUM_CELLS*DUTY_W-1:0] duty_codes,
   input  logic                        tmr_load,
   input  logic [TMR_W-1:0]            tmr_value,
   output logic [NUM_CELLS-1:0]        sw_on,
   output logic                        tmr_expired
);
   logic [DUTY_W-1:0]    slot_idx;
   logic                 period_tick;
   logic                 pwm_allow;
   logic [NUM_CELLS-1:0] sw_next;

   generate
      if (NUM_CELLS < 1) begin : g_bad_cells
         $error("bleed_switch_ctrl: NUM_CELLS must be at least 1");
      end
      if (DUTY_W < 1 || DUTY_W > 8) begin : g_bad_duty
         $error("bleed_switch_ctrl: DUTY_W must lie in 1..8");
      end
   endgenerate

   bleed_timebase #(
      .SLOT_TICKS (SLOT_TICKS),
      .DUTY_W     (DUTY_W)
   ) u_timebase (
      .clk         (clk),
      .rst_n       (rst_n),
      .slot_idx    (slot_idx),
      .period_tick (period_tick)
   );

   bleed_dis_timer #(
      .TMR_W (TMR_W)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (tmr_load),
      .load_val    (tmr_value),
      .period_tick (period_tick),
      .expired     (tmr_expired)
   );

   assign pwm_allow = !tmr_expired;

   generate
      for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
         bleed_cell_resolve #(
            .DUTY_W (DUTY_W)
         ) u_resolve (
            .thermal   (therm_shdn),
            .mute      (mute),
            .direct    (direct_en[c]),
            .adc_busy  (adc_busy),
            .pwm_allow (pwm_allow),
            .slot_idx  (slot_idx),
            .duty      (duty_codes[c*DUTY_W +: DUTY_W]),
            .sw_next   (sw_next[c])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_on <= '0;
      end else begin
         sw_on <= sw_next;
      end
   end

endmodule

// File: rtl/bleed_switch_ctrl_chk.sv
module bleed_switch_ctrl_chk #(
   parameter int NUM_CELLS = 16,
   parameter int DUTY_W    = 4,
   parameter int TMR_W     = 12
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        therm_shdn,
   input logic                        mute,
   input logic [NUM_CELLS-1:0]        direct_en,
   input logic                        adc_busy,
   input logic [NUM_CELLS*DUTY_W-1:0] duty_codes,
   input logic                        tmr_load,
   input logic [TMR_W-1:0]            tmr_value,
   input logic [NUM_CELLS-1:0]        sw_on,
   input logic                        tmr_expired
);
   // R1
   thermal_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      therm_shdn |=> (sw_on == '0));

   // R2
   mute_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mute |=> (sw_on == '0));

   // R3
   direct_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!therm_shdn && !mute) |=> ((sw_on & $past(direct_en)) == $past(direct_en)));

   // R4
   adc_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!therm_shdn && !mute && adc_busy) |=> ((sw_on & ~$past(direct_en)) == '0));

   // R7
   expired_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_expired |=> ((sw_on & ~$past(direct_en)) == '0));

   // R6
   load_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_load && (tmr_value == '0)) |=> tmr_expired);

   // R9
   load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_load && (tmr_value != '0)) |=> !tmr_expired);

   // R9
   expired_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_expired && !tmr_load) |=> tmr_expired);

   generate
      for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
         // R5
         duty_zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!direct_en[c] && (duty_codes[c*DUTY_W +: DUTY_W] == '0)) |=> !sw_on[c]);
      end
   endgenerate

endmodule

bind bleed_switch_ctrl bleed_switch_ctrl_chk #(
   .NUM_CELLS (NUM_CELLS),
   .DUTY_W    (DUTY_W),
   .TMR_W     (TMR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .therm_shdn  (therm_shdn),
   .mute        (mute),
   .direct_en   (direct_en),
   .adc_busy    (adc_busy),
   .duty_codes  (duty_codes),
   .tmr_load    (tmr_load),
   .tmr_value   (tmr_value),
   .sw_on       (sw_on),
   .tmr_expired (tmr_expired)
);

// File: tb/bleed_switch_ctrl_tb.sv
`timescale 1ns/1ps
module bleed_switch_ctrl_tb;
   localparam int NC    = 16;
   localparam int DW    = 4;
   localparam int ST    = 3;
   localparam int TW    = 12;
   localparam int FRAME = 16 * ST;

   typedef struct {
      string       tag;
      bit          direct;   // 1: compare got with exp, 0: compare outputs
      logic [31:0] exp;
      logic [31:0] got;
   } sb_item_t;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 therm_shdn = 1'b0;
   logic                 mute = 1'b0;
   logic [NC-1:0]        direct_en = '0;
   logic                 adc_busy = 1'b0;
   logic [NC*DW-1:0]     duty_codes = '0;
   logic                 tmr_load = 1'b0;
   logic [TW-1:0]        tmr_value = '0;
   logic [NC-1:0]        sw_on;
   logic                 tmr_expired;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   sb_item_t sb_q[$];
   int on_cnt[NC];

   always #2 clk = ~clk;

   bleed_switch_ctrl #(
      .NUM_CELLS (NC), .DUTY_W (DW), .SLOT_TICKS (ST), .TMR_W (TW)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .therm_shdn (therm_shdn), .mute (mute),
      .direct_en (direct_en), .adc_busy (adc_busy), .duty_codes (duty_codes),
      .tmr_load (tmr_load), .tmr_value (tmr_value),
      .sw_on (sw_on), .tmr_expired (tmr_expired)
   );

   // Monitor: pops expected items and compares them at the falling edge.
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         sb_item_t it;
         logic [31:0] act;
         it = sb_q.pop_front();
         act = it.direct ? it.got : {15'd0, tmr_expired, sw_on};
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
         end
      end
   end

   task automatic push_state(input string tag, input logic [31:0] exp);
      sb_item_t it;
      it.tag = tag; it.direct = 1'b0; it.exp = exp; it.got = '0;
      sb_q.push_back(it);
   endtask

   task automatic push_value(input string tag, input logic [31:0] got, input logic [31:0] exp);
      sb_item_t it;
      it.tag = tag; it.direct = 1'b1; it.exp = exp; it.got = got;
      sb_q.push_back(it);
   endtask

   // Inputs already set at a falling edge; outputs settle after one rising edge.
   task automatic expect_after_edge(input string tag, input logic exp_expired, input logic [NC-1:0] exp_sw);
      @(posedge clk);
      push_state(tag, {15'd0, exp_expired, exp_sw});
      @(negedge clk);
   endtask

   task automatic set_all_duty(input logic [DW-1:0] code);
      for (int i = 0; i < NC; i++) duty_codes[i*DW +: DW] = code;
   endtask

   task automatic load_timer(input logic [TW-1:0] v);
      tmr_load = 1'b1; tmr_value = v;
      @(negedge clk);
      tmr_load = 1'b0;
   endtask

   // Count on-cycles per cell across exactly one frame, after settling.
   task automatic measure_frame();
      @(negedge clk); @(negedge clk);
      for (int i = 0; i < NC; i++) on_cnt[i] = 0;
      for (int k = 0; k < FRAME; k++) begin
         for (int i = 0; i < NC; i++) on_cnt[i] += int'(sw_on[i]);
         @(negedge clk);
      end
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int t;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R8: reset state, countdown empty
      push_value("R8 reset sw_on", {16'd0, sw_on}, 32'd0);
      push_value("R8 reset expired", {31'd0, tmr_expired}, 32'd1);
      @(negedge clk);

      // R3: forced-on mask with nothing else
      direct_en = 16'hA5A5;
      expect_after_edge("R3 direct mask", 1'b1, 16'hA5A5);
      // R3 and R4: mask survives the measurement pause
      adc_busy = 1'b1;
      expect_after_edge("R3 R4 direct under adc", 1'b1, 16'hA5A5);
      // R2: mute beats the mask
      mute = 1'b1;
      expect_after_edge("R2 mute over direct", 1'b1, 16'h0000);
      // R1: thermal beats everything
      mute = 1'b0; therm_shdn = 1'b1;
      expect_after_edge("R1 thermal over direct", 1'b1, 16'h0000);
      therm_shdn = 1'b0; adc_busy = 1'b0;
      // R8: output follows one cycle later
      direct_en = 16'h0F00;
      expect_after_edge("R8 one cycle latency", 1'b1, 16'h0F00);

      // R6 R9: nonzero load clears expiry next cycle
      direct_en = '0;
      tmr_load = 1'b1; tmr_value = 12'd3;
      expect_after_edge("R9 load clears expired", 1'b0, 16'h0000);
      tmr_load = 1'b0;

      // R6: expiry arrives after roughly three frames
      t = 0;
      while (!tmr_expired && t < 10 * FRAME) begin @(negedge clk); t++; end
      push_value("R6 expiry window", {31'd0, (t >= 2*FRAME) && (t <= 3*FRAME + 2)}, 32'd1);
      @(negedge clk);
      // R9: expiry holds without a reload
      repeat (FRAME) @(negedge clk);
      push_value("R9 expired holds", {31'd0, tmr_expired}, 32'd1);
      @(negedge clk);

      // R5: per-cell duty code i gives i*ST on-cycles per frame
      load_timer(12'd2000);
      for (int i = 0; i < NC; i++) duty_codes[i*DW +: DW] = DW'(i);
      measure_frame();
      for (int i = 0; i < NC; i++)
         push_value($sformatf("R5 duty cell %0d", i), on_cnt[i], i * ST);
      @(negedge clk);

      // R4 + R3 collision: full duty, pause, mask on cell 0 and cell 9
      set_all_duty(4'hF); adc_busy = 1'b1; direct_en = 16'h0201;
      measure_frame();
      push_value("R3 forced cell0 under pause", on_cnt[0], FRAME);
      push_value("R3 forced cell9 under pause", on_cnt[9], FRAME);
      push_value("R4 paused cell5", on_cnt[5], 0);
      @(negedge clk);

      // R5: full duty without pause gives 15 of 16 slots
      adc_busy = 1'b0; direct_en = '0;
      measure_frame();
      push_value("R5 duty 15 cell3", on_cnt[3], 15 * ST);
      @(negedge clk);

      // R2: mute silences running bleeding
      mute = 1'b1;
      measure_frame();
      push_value("R2 mute during pwm", on_cnt[7], 0);
      @(negedge clk);
      mute = 1'b0;

      // R1: thermal silences running bleeding
      therm_shdn = 1'b1; direct_en = 16'hFFFF;
      measure_frame();
      push_value("R1 thermal during pwm", on_cnt[12], 0);
      @(negedge clk);
      therm_shdn = 1'b0; direct_en = 16'h0004;

      // R6 R7: load zero expires at once and stops bleeding, mask stays
      tmr_load = 1'b1; tmr_value = '0;
      @(posedge clk);
      push_value("R6 load zero", 32'd0, 32'd0);
      @(negedge clk);
      tmr_load = 1'b0;
      push_value("R6 expired after zero load", {31'd0, tmr_expired}, 32'd1);
      measure_frame();
      push_value("R7 pwm stopped cell1", on_cnt[1], 0);
      push_value("R7 forced cell2 still on", on_cnt[2], FRAME);
      @(negedge clk); @(negedge clk);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule